// File: doc/BRIEF.md
# Message Object Transfer Sequencer

This block copies one message object at a time between a set of CPU-visible staging registers and a single-port message RAM. The CPU fills the staging registers (or leaves them to be loaded), then writes a command word whose lowest byte names the message object. That write starts the transfer. The same word picks the direction and which field groups take part: the acceptance mask, the arbitration fields, the control fields, and the two data halves. Groups that are not selected keep their old contents at the destination.

Every transfer reads the whole object, merges it, and writes it back. This lets the block also clear the interrupt-pending or new-data flags of the object, or set its transmit request, as part of the command. While a transfer runs, a busy flag is raised and the staging registers refuse CPU writes. One further start command may be written during that time. It is held and begins as soon as the running one ends. A protocol-engine requester shares the RAM port with fixed priority, and the sequencer waits whenever that requester holds the port.

Top module: `msgxfer_top`

## Requirements
- R1: A CPU write to address 0 with byte lane 0 enabled starts a transfer, and `busy` (also command bit 15) reads 1 from the next cycle. A write to address 0 without lane 0 starts nothing.
- R2: With `coreReq` held low, `busy` stays 1 for exactly 4 clock cycles per transfer.
- R3: A start written while `busy` is 1 and nothing is held is queued and runs right after the current transfer, with `busy` staying 1 throughout (8 cycles for two). A start written while one is already held is discarded.
- R4: While `busy` is 1, CPU writes to addresses 1 to 5 change nothing, and command writes without lane 0 leave the command word unchanged.
- R5: Command bit 23 picks the direction: 0 copies the RAM object into the staging registers, and 1 copies the staging registers into the RAM object.
- R6: Command bits 22 (mask, address 1), 21 (arbitration, address 2), 20 (control, address 3), 17 (data half A, address 4) and 16 (data half B, address 5) each select one group. An unselected group is left unchanged at the destination.
- R7: On a read (bit 23 = 0), bit 19 clears the object's interrupt-pending flag (address 3 bit 9) and bit 18 clears its new-data flag (address 3 bit 10). The staging registers receive the values from before the clear. On a write, bit 18 sets the object's transmit request (address 3 bit 8) after the control copy, and bit 19 has no effect.
- R8: Message number N addresses object N mod 2^IDX_W, and a result of 0 addresses object 1.
- R9: Address 0 reads back bits 23:16 and 7:0 as last accepted, bit 15 as `busy`, and every other bit as zero. Lane 2 alone updates bits 23:16 while idle.
- R10: While `coreReq` is 1, the RAM port serves the core, and each such cycle in which the sequencer needs the port adds one cycle to the transfer.
- R11: After reset, `busy` is 0 and addresses 0 to 5 read zero.
- R12: Staging register layout. Address 1: mask identifier [28:0], mask-direction bit 30, mask-extended bit 31. Address 2: identifier [28:0], direction bit 29, extended bit 30, valid bit 31. Address 3: control [7:0], plus the flags of R7. Addresses 4 and 5: 32 data bits. Bits not named read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuWrEn | input | 1 | CPU write strobe |
| cpuAddr | input | 3 | CPU register address |
| cpuBe | input | 4 | CPU byte-lane enables |
| cpuWData | input | 32 | CPU write data |
| cpuRdData | output | 32 | CPU read data for `cpuAddr` (combinational) |
| busy | output | 1 | Transfer active or queued |
| coreReq | input | 1 | Protocol-engine RAM request, highest priority |
| coreWe | input | 1 | Protocol-engine write (else read) |
| coreAddr | input | IDX_W | Protocol-engine object index |
| coreWData | input | 138 | Protocol-engine write object |
| coreRData | output | 138 | RAM read data, one cycle after a read |

## Verification
A wrong sequencer state shows at the ports as a busy period of the wrong length. The checker therefore compares the number of `busy` cycles against the expected count as soon as the flag falls, including queued pairs and core stalls. Damage to the merge or to the group selection appears only when the affected object is copied back to the staging registers. So every write-direction transfer is followed, a few cycles later, by a read-back that compares all five staging words. A broken write lock shows up on the first readback after the transfer in which the CPU wrote.

// File: rtl/msgxfer_pkg.sv
package msgxfer_pkg;
  localparam int ID_W   = 29;
  localparam int CTL_W  = 8;
  localparam int HALF_W = 32;
  localparam int REG_W  = 32;

  localparam int A_CMD  = 0;
  localparam int A_MASK = 1;
  localparam int A_ARB  = 2;
  localparam int A_CTL  = 3;
  localparam int A_DATA = 4;
  localparam int A_DATB = 5;

  typedef struct packed {
    logic [ID_W-1:0] idMask;
    logic            mDir;
    logic            mXtd;
  } maskGrp_t;

  typedef struct packed {
    logic [ID_W-1:0] id;
    logic            dir;
    logic            xtd;
    logic            msgVal;
  } arbGrp_t;

  typedef struct packed {
    logic [CTL_W-1:0] ctl;
    logic             txRqst;
    logic             intPnd;
    logic             newDat;
  } ctlGrp_t;

  typedef struct packed {
    maskGrp_t          msk;
    arbGrp_t           arb;
    ctlGrp_t           ctl;
    logic [HALF_W-1:0] dA;
    logic [HALF_W-1:0] dB;
  } msgObj_t;

  typedef struct packed {
    logic       wr;
    logic       selMask;
    logic       selArb;
    logic       selCtl;
    logic       clrInt;
    logic       txNd;
    logic       selA;
    logic       selB;
    logic [7:0] msgNum;
  } cmd_t;

  typedef struct packed {
    logic ramRd;
    logic merge;
    logic ramWr;
  } strb_t;

  typedef enum logic [2:0] {S_IDLE, S_RDREQ, S_MERGE, S_WRBK, S_DONE} seqState_t;

  function automatic logic [REG_W-1:0] beMerge(input logic [REG_W-1:0] oldW,
                                               input logic [REG_W-1:0] newW,
                                               input logic [3:0] be);
    logic [REG_W-1:0] r;
    r = oldW;
    for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = newW[8*b +: 8];
    return r;
  endfunction

  function automatic logic [REG_W-1:0] packMask(input maskGrp_t m);
    logic [REG_W-1:0] w;
    w = '0; w[ID_W-1:0] = m.idMask; w[30] = m.mDir; w[31] = m.mXtd;
    return w;
  endfunction

  function automatic maskGrp_t unpackMask(input logic [REG_W-1:0] w);
    maskGrp_t m;
    m.idMask = w[ID_W-1:0]; m.mDir = w[30]; m.mXtd = w[31];
    return m;
  endfunction

  function automatic logic [REG_W-1:0] packArb(input arbGrp_t a);
    logic [REG_W-1:0] w;
    w = '0; w[ID_W-1:0] = a.id; w[29] = a.dir; w[30] = a.xtd; w[31] = a.msgVal;
    return w;
  endfunction

  function automatic arbGrp_t unpackArb(input logic [REG_W-1:0] w);
    arbGrp_t a;
    a.id = w[ID_W-1:0]; a.dir = w[29]; a.xtd = w[30]; a.msgVal = w[31];
    return a;
  endfunction

  function automatic logic [REG_W-1:0] packCtl(input ctlGrp_t c);
    logic [REG_W-1:0] w;
    w = '0; w[CTL_W-1:0] = c.ctl; w[8] = c.txRqst; w[9] = c.intPnd; w[10] = c.newDat;
    return w;
  endfunction

  function automatic ctlGrp_t unpackCtl(input logic [REG_W-1:0] w);
    ctlGrp_t c;
    c.ctl = w[CTL_W-1:0]; c.txRqst = w[8]; c.intPnd = w[9]; c.newDat = w[10];
    return c;
  endfunction
endpackage

// File: rtl/msgxfer_ctrl.sv
module msgxfer_ctrl
  import msgxfer_pkg::*;
#(
  parameter int IDX_W  = 5,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuWrEn,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [1:0]        cmdBe,
  input  logic [15:0]       cmdWData,
  input  logic              coreReq,
  output logic              busy,
  output cmd_t              actCmd,
  output strb_t             strb,
  output logic [IDX_W-1:0]  ramIdx
);
  seqState_t        state;
  cmd_t             cmdQ, pendQ, cmdNext;
  logic             pendV;
  logic             cmdWr, startNew, takePend, directStart, capPend;
  logic [IDX_W-1:0] idxRaw;

  assign cmdWr       = cpuWrEn && (cpuAddr == ADDR_W'(A_CMD));
  assign startNew    = cmdWr && cmdBe[0];
  assign takePend    = (state == S_DONE) && pendV;
  assign directStart = startNew && ((state == S_IDLE) || ((state == S_DONE) && !pendV));
  assign capPend     = startNew && !directStart && (!pendV || takePend);

  always_comb begin
    cmdNext = cmdQ;
    if (cmdBe[1]) cmdNext[15:8] = cmdWData[15:8];
    if (cmdBe[0]) cmdNext.msgNum = cmdWData[7:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      cmdQ  <= '0;
      pendQ <= '0;
      pendV <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (cmdWr) cmdQ <= cmdNext;
          if (startNew) state <= S_RDREQ;
        end
        S_RDREQ: if (!coreReq) state <= S_MERGE;
        S_MERGE: state <= S_WRBK;
        S_WRBK:  if (!coreReq) state <= S_DONE;
        S_DONE: begin
          if (pendV) begin
            cmdQ  <= pendQ;
            state <= S_RDREQ;
          end else if (startNew) begin
            cmdQ  <= cmdNext;
            state <= S_RDREQ;
          end else begin
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
      if (capPend) begin
        pendV <= 1'b1;
        pendQ <= cmdNext;
      end else if (takePend) begin
        pendV <= 1'b0;
      end
    end
  end

  assign busy   = (state != S_IDLE);
  assign actCmd = cmdQ;
  assign idxRaw = cmdQ.msgNum[IDX_W-1:0];
  assign ramIdx = (idxRaw == '0) ? IDX_W'(1) : idxRaw;

  always_comb begin
    strb.ramRd = (state == S_RDREQ) && !coreReq;
    strb.merge = (state == S_MERGE);
    strb.ramWr = (state == S_WRBK) && !coreReq;
  end

  // R1: an accepted start raises busy on the next cycle
  a_r1_busy_after_start: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && startNew) |=> busy);
  // R3: a held command follows without an idle gap
  a_r3_pend_follows: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_DONE && pendV) |=> (state == S_RDREQ));
  // R3: a held command never coexists with an idle sequencer
  a_r3_pend_keeps_busy: assert property (@(posedge clk) disable iff (!rstN)
    pendV |-> busy);
  // R10: core ownership freezes the read request
  a_r10_stall_read: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RDREQ && coreReq) |=> (state == S_RDREQ));
  // R10: core ownership freezes the write-back
  a_r10_stall_write: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WRBK && coreReq) |=> (state == S_WRBK));
endmodule

// File: rtl/msgxfer_dpath.sv
module msgxfer_dpath
  import msgxfer_pkg::*;
#(
  parameter int IDX_W  = 5,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuWrEn,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [3:0]        cpuBe,
  input  logic [REG_W-1:0]  cpuWData,
  output logic [REG_W-1:0]  cpuRdData,
  input  logic              busy,
  input  cmd_t              actCmd,
  input  strb_t             strb,
  input  logic [IDX_W-1:0]  ramIdx,
  input  logic              coreReq,
  input  logic              coreWe,
  input  logic [IDX_W-1:0]  coreAddr,
  input  msgObj_t           coreWData,
  output msgObj_t           coreRData
);
  localparam int DEPTH = 1 << IDX_W;

  msgObj_t          mem [DEPTH];
  msgObj_t          ramQ, objQ, ifObj, mergedObj, ifNext, ramD;
  logic [IDX_W-1:0] ramAddr;
  logic             ramWe, ramRe;

  // single RAM port, core first
  assign ramAddr = coreReq ? coreAddr  : ramIdx;
  assign ramWe   = coreReq ? coreWe    : strb.ramWr;
  assign ramRe   = coreReq ? !coreWe   : strb.ramRd;
  assign ramD    = coreReq ? coreWData : objQ;

  always_ff @(posedge clk) begin
    if (ramWe) mem[ramAddr] <= ramD;
    if (ramRe) ramQ <= mem[ramAddr];
  end

  assign coreRData = ramQ;

  always_comb begin
    mergedObj = ramQ;
    ifNext    = ifObj;
    if (actCmd.wr) begin
      if (actCmd.selMask) mergedObj.msk = ifObj.msk;
      if (actCmd.selArb)  mergedObj.arb = ifObj.arb;
      if (actCmd.selCtl)  mergedObj.ctl = ifObj.ctl;
      if (actCmd.selA)    mergedObj.dA  = ifObj.dA;
      if (actCmd.selB)    mergedObj.dB  = ifObj.dB;
      if (actCmd.txNd)    mergedObj.ctl.txRqst = 1'b1;
    end else begin
      if (actCmd.selMask) ifNext.msk = ramQ.msk;
      if (actCmd.selArb)  ifNext.arb = ramQ.arb;
      if (actCmd.selCtl)  ifNext.ctl = ramQ.ctl;
      if (actCmd.selA)    ifNext.dA  = ramQ.dA;
      if (actCmd.selB)    ifNext.dB  = ramQ.dB;
      if (actCmd.clrInt)  mergedObj.ctl.intPnd = 1'b0;
      if (actCmd.txNd)    mergedObj.ctl.newDat = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      objQ  <= '0;
      ifObj <= '0;
    end else if (strb.merge) begin
      objQ  <= mergedObj;
      ifObj <= ifNext;
    end else if (cpuWrEn && !busy) begin
      case (cpuAddr)
        ADDR_W'(A_MASK): ifObj.msk <= unpackMask(beMerge(packMask(ifObj.msk), cpuWData, cpuBe));
        ADDR_W'(A_ARB):  ifObj.arb <= unpackArb(beMerge(packArb(ifObj.arb), cpuWData, cpuBe));
        ADDR_W'(A_CTL):  ifObj.ctl <= unpackCtl(beMerge(packCtl(ifObj.ctl), cpuWData, cpuBe));
        ADDR_W'(A_DATA): ifObj.dA  <= beMerge(ifObj.dA, cpuWData, cpuBe);
        ADDR_W'(A_DATB): ifObj.dB  <= beMerge(ifObj.dB, cpuWData, cpuBe);
        default: ;
      endcase
    end
  end

  always_comb begin
    case (cpuAddr)
      ADDR_W'(A_CMD):  cpuRdData = {8'h00, actCmd[15:8], busy, 7'h00, actCmd.msgNum};
      ADDR_W'(A_MASK): cpuRdData = packMask(ifObj.msk);
      ADDR_W'(A_ARB):  cpuRdData = packArb(ifObj.arb);
      ADDR_W'(A_CTL):  cpuRdData = packCtl(ifObj.ctl);
      ADDR_W'(A_DATA): cpuRdData = ifObj.dA;
      ADDR_W'(A_DATB): cpuRdData = ifObj.dB;
      default:         cpuRdData = '0;
    endcase
  end

  // R4: staging registers hold still under CPU writes while busy
  a_r4_if_locked: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cpuWrEn && cpuAddr != ADDR_W'(A_CMD) && !strb.merge) |=> $stable(ifObj));
  // R10: the sequencer never drives the RAM while the core owns it
  a_r10_core_first: assert property (@(posedge clk) disable iff (!rstN)
    coreReq |-> !(strb.ramRd || strb.ramWr));
  // R2: RAM traffic of the sequencer happens only inside a busy period
  a_r2_ram_in_busy: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ramRd || strb.ramWr || strb.merge) |-> busy);
endmodule

// File: rtl/msgxfer_top.sv
module msgxfer_top
  import msgxfer_pkg::*;
#(
  parameter  int IDX_W  = 5,
  parameter  int ADDR_W = 3,
  localparam int OBJ_W  = $bits(msgObj_t)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuWrEn,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [3:0]        cpuBe,
  input  logic [REG_W-1:0]  cpuWData,
  output logic [REG_W-1:0]  cpuRdData,
  output logic              busy,
  input  logic              coreReq,
  input  logic              coreWe,
  input  logic [IDX_W-1:0]  coreAddr,
  input  logic [OBJ_W-1:0]  coreWData,
  output logic [OBJ_W-1:0]  coreRData
);
  cmd_t             actCmd;
  strb_t            strb;
  logic [IDX_W-1:0] ramIdx;
  msgObj_t          coreWObj, coreRObj;

  assign coreWObj  = coreWData;
  assign coreRData = coreRObj;

  msgxfer_ctrl #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .cpuWrEn(cpuWrEn), .cpuAddr(cpuAddr),
    .cmdBe({cpuBe[2], cpuBe[0]}), .cmdWData({cpuWData[23:16], cpuWData[7:0]}),
    .coreReq(coreReq), .busy(busy), .actCmd(actCmd), .strb(strb), .ramIdx(ramIdx)
  );

  msgxfer_dpath #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) dpath_i (
    .clk(clk), .rstN(rstN), .cpuWrEn(cpuWrEn), .cpuAddr(cpuAddr), .cpuBe(cpuBe),
    .cpuWData(cpuWData), .cpuRdData(cpuRdData), .busy(busy), .actCmd(actCmd),
    .strb(strb), .ramIdx(ramIdx), .coreReq(coreReq), .coreWe(coreWe),
    .coreAddr(coreAddr), .coreWData(coreWObj), .coreRData(coreRObj)
  );
endmodule

// File: tb/msgxfer_top_tb_top.sv
module msgxfer_top_tb_top;
  localparam int IDX_W = 5;
  localparam int OBJ_W = $bits(msgxfer_pkg::msgObj_t);

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             cpuWrEn = 1'b0;
  logic [2:0]       cpuAddr = '0;
  logic [3:0]       cpuBe = '0;
  logic [31:0]      cpuWData = '0;
  logic [31:0]      cpuRdData;
  logic             busy;
  logic             coreReq = 1'b0;
  logic             coreWe = 1'b0;
  logic [IDX_W-1:0] coreAddr = '0;
  logic [OBJ_W-1:0] coreWData = '0;
  logic [OBJ_W-1:0] coreRData;

  msgxfer_top #(.IDX_W(IDX_W)) dut_i (
    .clk(clk), .rstN(rstN), .cpuWrEn(cpuWrEn), .cpuAddr(cpuAddr), .cpuBe(cpuBe),
    .cpuWData(cpuWData), .cpuRdData(cpuRdData), .busy(busy), .coreReq(coreReq),
    .coreWe(coreWe), .coreAddr(coreAddr), .coreWData(coreWData), .coreRData(coreRData)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int expQ[$];
  logic [31:0] memM [32][6];
  logic [31:0] ifM [6];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  function automatic logic [31:0] vmask(input int g);
    case (g)
      1: return 32'hDFFF_FFFF;
      3: return 32'h0000_07FF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic int selBit(input int g);
    case (g)
      1: return 22;
      2: return 21;
      3: return 20;
      4: return 17;
      default: return 16;
    endcase
  endfunction

  task automatic applyModel(input logic [31:0] c);
    int idx;
    idx = int'(c[7:0]) % 32;
    if (idx == 0) idx = 1;
    for (int g = 1; g <= 5; g++)
      if (c[selBit(g)]) begin
        if (c[23]) memM[idx][g] = ifM[g];
        else ifM[g] = memM[idx][g];
      end
    if (c[23]) begin
      if (c[18]) memM[idx][3] = memM[idx][3] | 32'h100;
    end else begin
      if (c[19]) memM[idx][3] = memM[idx][3] & ~32'h200;
      if (c[18]) memM[idx][3] = memM[idx][3] & ~32'h400;
    end
  endtask

  task automatic cpuWrite(input logic [2:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cpuAddr = a; cpuBe = be; cpuWData = d; cpuWrEn = 1'b1;
    @(posedge clk);
    #1 cpuWrEn = 1'b0;
  endtask

  task automatic cpuRead(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    cpuAddr = a;
    #1 d = cpuRdData;
  endtask

  task automatic setIf(input int g, input logic [31:0] d);
    cpuWrite(3'(g), 4'hF, d);
    ifM[g] = d & vmask(g);
  endtask

  task automatic issue(input logic [31:0] c, input int lat);
    cpuWrite(3'd0, 4'hF, c);
    applyModel(c);
    if (lat > 0) expQ.push_back(lat);
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic checkIf(input string req);
    logic [31:0] d;
    for (int g = 1; g <= 5; g++) begin
      cpuRead(3'(g), d);
      chk(req, d, ifM[g]);
    end
  endtask

  task automatic coreHold(input int skip, input int n);
    repeat (skip) @(negedge clk);
    @(negedge clk);
    coreAddr = 5'd7; coreWe = 1'b0; coreReq = 1'b1;
    repeat (n) @(negedge clk);
    coreReq = 1'b0;
  endtask

  // scoreboard monitor: busy period length per expected item (R2, R3, R10)
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (busy === 1'b1) cnt++;
      else if (cnt > 0) begin
        if (expQ.size() == 0) chk("R2 unexpected busy period", 32'(cnt), 32'd0);
        else chk("R2 busy length", 32'(cnt), 32'(expQ.pop_front()));
        cnt = 0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog act=running exp=done");
    summary();
  end

  initial begin
    logic [31:0] d;
    int objs[4] = '{1, 2, 5, 31};
    for (int g = 0; g < 6; g++) ifM[g] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R11 reset state
    chk("R11 busy", {31'd0, busy}, 32'd0);
    for (int a = 0; a <= 5; a++) begin
      cpuRead(3'(a), d);
      chk("R11 reg", d, 32'd0);
    end
    // R9 lane 2 only: fields update, no start (R1)
    cpuWrite(3'd0, 4'b0100, 32'h00A0_0000);
    cpuRead(3'd0, d);
    chk("R9 lane2 idle", d, 32'h00A0_0000);
    chk("R1 no start", {31'd0, busy}, 32'd0);
    // seed objects, full write direction (R5, R12)
    foreach (objs[i]) begin
      setIf(1, 32'h8123_4500 ^ objs[i]);
      setIf(2, 32'hA000_0000 | (objs[i] << 4));
      setIf(3, 32'h0000_0600 | objs[i]);
      setIf(4, 32'h1111_0000 + objs[i]);
      setIf(5, 32'hFFFF_0000 - objs[i]);
      issue(32'h00F3_0000 | objs[i], 4);
      waitIdle();
    end
    // R5 full read of object 2, command readback while busy (R1, R9)
    for (int g = 1; g <= 5; g++) setIf(g, 32'h0);
    issue(32'h0073_0002, 4);
    cpuRead(3'd0, d);
    chk("R1 R9 busy readback", d, 32'h0073_8002);
    waitIdle();
    checkIf("R5 read all");
    // R6 partial read: arbitration and data B of object 5
    for (int g = 1; g <= 5; g++) setIf(g, 32'h5A5A_5A5A);
    issue(32'h0021_0005, 4);
    waitIdle();
    checkIf("R6 partial read");
    // R6 partial write: mask and data A into object 1
    setIf(1, 32'h8000_0ABC);
    setIf(2, 32'h0);
    setIf(4, 32'hCAFE_0001);
    issue(32'h00C2_0001, 4);
    waitIdle();
    for (int g = 1; g <= 5; g++) setIf(g, 32'h0);
    issue(32'h0073_0001, 4);
    waitIdle();
    checkIf("R6 partial write");
    // R7 read with flag clears on object 31
    issue(32'h001C_001F, 4);
    waitIdle();
    checkIf("R7 pre-clear copy");
    issue(32'h0010_001F, 4);
    waitIdle();
    checkIf("R7 flags cleared");
    // R7 write with transmit request, clear-interrupt ignored
    setIf(3, 32'h0000_0203);
    issue(32'h009C_0002, 4);
    waitIdle();
    setIf(3, 32'h0);
    issue(32'h0010_0002, 4);
    waitIdle();
    checkIf("R7 txrqst set");
    // R8 aliasing: 37 -> 5, 0 -> 1, 32 -> 1
    setIf(4, 32'h7777_0025);
    issue(32'h0082_0025, 4);
    waitIdle();
    setIf(4, 32'h0);
    issue(32'h0002_0005, 4);
    waitIdle();
    checkIf("R8 n37");
    issue(32'h0073_0000, 4);
    waitIdle();
    checkIf("R8 n0");
    for (int g = 1; g <= 5; g++) setIf(g, 32'h0);
    issue(32'h0073_0020, 4);
    waitIdle();
    checkIf("R8 n32");
    // R4 write protection while busy
    issue(32'h0010_0002, 4);
    cpuWrite(3'd4, 4'hF, 32'hDEAD_BEEF);
    cpuWrite(3'd0, 4'b0100, 32'h00FF_0000);
    cpuRead(3'd0, d);
    chk("R4 cmd locked busy", d, 32'h0010_8002);
    waitIdle();
    checkIf("R4 if locked");
    cpuRead(3'd0, d);
    chk("R4 cmd after", d, 32'h0010_0002);
    // R3 queue: second runs, third dropped
    setIf(5, 32'h3333_3333);
    issue(32'h0081_0002, 8);
    issue(32'h0001_0005, 0);
    cpuWrite(3'd0, 4'hF, 32'h0081_0001);
    waitIdle();
    checkIf("R3 queued read");
    issue(32'h0001_0001, 4);
    waitIdle();
    checkIf("R3 third dropped");
    issue(32'h0001_0002, 4);
    waitIdle();
    checkIf("R3 first done");
    // R10 / R2 stalls by the core requester
    issue(32'h0073_0002, 7);
    coreHold(0, 3);
    waitIdle();
    checkIf("R10 read stall");
    issue(32'h0073_0005, 6);
    coreHold(2, 2);
    waitIdle();
    checkIf("R10 write stall");
    repeat (3) @(negedge clk);
    chk("R2 scoreboard drained", 32'(expQ.size()), 32'd0);
    summary();
  end
endmodule